// File: doc/BRIEF.md
# Rotating Integer and Predicate Register File

This block holds the architectural integer and predicate state of a wide-issue core. The integer file has 128 entries. Each entry has 64 data bits and one tag bit that marks a deferred exception. The predicate file has 64 one-bit entries. Each file is split into a low fixed region and a high region.

Logical indices in the fixed region select the same physical entry. Logical indices in the high region are renamed by adding a per-file rotation offset, modulo the region size. This lets the code of a software-pipelined loop use the same register names in every iteration, while each iteration works on fresh physical storage.

Each file has two combinational read ports and one write port that takes effect at the clock edge. A one-cycle step input advances both offsets together. A clear input returns both offsets to zero. Entry 0 of each file is a constant.

Top module: `rot_regfile`

## Requirements
- R1: An integer write to a logical index other than 0 stores the 64 data bits and the tag bit. A later read of the same logical index, with the same rotation offset, returns both.
- R2: Integer index 0 always reads as data 0 with the tag bit 0. A write to it has no effect, including a write that sets the tag bit.
- R3: Predicate index 0 always reads as 1. A write to it has no effect.
- R4: Integer indices 0 to 31 and predicate indices 0 to 15 select their physical entry directly. Stepping or clearing the offsets never changes what they return.
- R5: A logical index i in a rotating region (integer start 32, size 96; predicate start 16, size 48) selects the physical entry start + ((i − start + offset) mod size). The integer file and the predicate file each use their own offset.
- R6: A step pulse lowers each offset by one at the clock edge, wrapping from 0 to size − 1. A value written at logical index i can then be read at logical index i + 1, and a value written at the top index of a region can be read at the region's first index.
- R7: A clear pulse sets both offsets to 0 at the clock edge. When step and clear are both asserted in one cycle, clear wins.
- R8: When a read and the write of the same file select the same physical entry in one cycle, the read returns the value being written. Both addresses are renamed before they are compared. Index 0 is excluded from this forwarding.
- R9: After reset every data bit and tag bit reads 0, predicate index 0 reads 1, and both offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rot_step | input | 1 | Lower both rotation offsets by one |
| base_clr | input | 1 | Return both rotation offsets to zero |
| int_ra_idx | input | 7 | Integer read port A logical index |
| int_ra_data | output | 64 | Integer read port A data |
| int_ra_nat | output | 1 | Integer read port A tag bit |
| int_rb_idx | input | 7 | Integer read port B logical index |
| int_rb_data | output | 64 | Integer read port B data |
| int_rb_nat | output | 1 | Integer read port B tag bit |
| int_we | input | 1 | Integer write enable |
| int_wa_idx | input | 7 | Integer write logical index |
| int_wa_data | input | 64 | Integer write data |
| int_wa_nat | input | 1 | Integer write tag bit |
| prd_ra_idx | input | 6 | Predicate read port A logical index |
| prd_ra_val | output | 1 | Predicate read port A value |
| prd_rb_idx | input | 6 | Predicate read port B logical index |
| prd_rb_val | output | 1 | Predicate read port B value |
| prd_we | input | 1 | Predicate write enable |
| prd_wa_idx | input | 6 | Predicate write logical index |
| prd_wa_val | input | 1 | Predicate write value |

## Verification
Values written at the first and last index of each rotating region are read one step later at the shifted names. This tells a correct decrement and wrap apart from an increment or a missing modulo. A full lap of 96 steps must bring back the original mapping, since 96 is a multiple of both region sizes. Reads and writes of the same logical name in one cycle, with a non-zero offset, separate forwarding after renaming from forwarding on raw indices. A long stretch of random reads, writes, steps and clears, compared against an independent model, covers the interactions among the fixed region, the constant entries and the simultaneous step and clear.

// File: rtl/rotrf_pkg.sv
package rotrf_pkg;
    // number of read ports per file
    localparam int unsigned RD_PORTS = 2;
    // renaming units per file: each read port plus the write port
    localparam int unsigned MAP_UNITS = RD_PORTS + 1;
    // index of the write port among the renaming units
    localparam int unsigned WR_SLOT = RD_PORTS;
endpackage

// File: rtl/rotrf_base.sv
// Rotation offset for one region: decrement on step, zero on clear.
module rotrf_base #(
    parameter int unsigned SIZE = 96,
    parameter int unsigned W    = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    output logic [W-1:0] base_o
);
    localparam logic [W-1:0] LAST = W'(SIZE - 1);

    typedef struct packed {
        logic [W-1:0] base;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.base = '0;
        end else if (step) begin
            s_d.base = (s_q.base == '0) ? LAST : s_q.base - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign base_o = s_q.base;
endmodule

// File: rtl/rotrf_map.sv
// Logical to physical index translation for one address.
module rotrf_map #(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned FIXED   = 32,
    parameter int unsigned W       = 7
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] base,
    output logic [W-1:0] phys
);
    localparam int unsigned ROT = ENTRIES - FIXED;

    logic [W:0] sum;

    always_comb begin
        sum  = '0;
        phys = idx;
        if (idx >= W'(FIXED)) begin
            sum = {1'b0, idx - W'(FIXED)} + {1'b0, base};
            if (sum >= (W+1)'(ROT)) begin
                sum = sum - (W+1)'(ROT);
            end
            phys = sum[W-1:0] + W'(FIXED);
        end
    end
endmodule

// File: rtl/rotrf_bank.sv
// Physical storage with a constant entry 0, write forwarding and reset clear.
module rotrf_bank #(
    parameter int unsigned     ENTRIES = 128,
    parameter int unsigned     WIDTH   = 65,
    parameter int unsigned     NREAD   = 2,
    parameter int unsigned     AW      = 7,
    parameter logic [WIDTH-1:0] CONST0 = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               wa,
    input  logic [WIDTH-1:0]            wd,
    input  logic [NREAD-1:0][AW-1:0]    ra,
    output logic [NREAD-1:0][WIDTH-1:0] rd
);
    typedef struct packed {
        logic [ENTRIES-1:0][WIDTH-1:0] mem;
    } state_t;

    state_t s_d, s_q;
    logic   wr_live;

    assign wr_live = we && (wa != '0);

    always_comb begin
        s_d = s_q;
        if (wr_live) begin
            s_d.mem[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NREAD; g++) begin : g_rd
        always_comb begin
            if (ra[g] == '0) begin
                rd[g] = CONST0;
            end else if (wr_live && (wa == ra[g])) begin
                rd[g] = wd;
            end else begin
                rd[g] = s_q.mem[ra[g]];
            end
        end
    end
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
    import rotrf_pkg::*;
#(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned INT_REGS  = 128,
    parameter int unsigned INT_FIXED = 32,
    parameter int unsigned PRD_REGS  = 64,
    parameter int unsigned PRD_FIXED = 16,
    localparam int unsigned IAW      = $clog2(INT_REGS),
    localparam int unsigned PAW      = $clog2(PRD_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rot_step,
    input  logic            base_clr,
    input  logic [IAW-1:0]  int_ra_idx,
    output logic [XLEN-1:0] int_ra_data,
    output logic            int_ra_nat,
    input  logic [IAW-1:0]  int_rb_idx,
    output logic [XLEN-1:0] int_rb_data,
    output logic            int_rb_nat,
    input  logic            int_we,
    input  logic [IAW-1:0]  int_wa_idx,
    input  logic [XLEN-1:0] int_wa_data,
    input  logic            int_wa_nat,
    input  logic [PAW-1:0]  prd_ra_idx,
    output logic            prd_ra_val,
    input  logic [PAW-1:0]  prd_rb_idx,
    output logic            prd_rb_val,
    input  logic            prd_we,
    input  logic [PAW-1:0]  prd_wa_idx,
    input  logic            prd_wa_val
);
    localparam int unsigned IWIDTH = XLEN + 1;
    localparam int unsigned IROT   = INT_REGS - INT_FIXED;
    localparam int unsigned PROT   = PRD_REGS - PRD_FIXED;

    logic [IAW-1:0] ibase;
    logic [PAW-1:0] pbase;

    logic [MAP_UNITS-1:0][IAW-1:0] ilog, iphys;
    logic [MAP_UNITS-1:0][PAW-1:0] plog, pphys;

    logic [RD_PORTS-1:0][IAW-1:0]    iraddr;
    logic [RD_PORTS-1:0][PAW-1:0]    praddr;
    logic [RD_PORTS-1:0][IWIDTH-1:0] irdata;
    logic [RD_PORTS-1:0][0:0]        prdata;

    rotrf_base #(.SIZE(IROT), .W(IAW)) u_ibase (
        .clk(clk), .rst_n(rst_n), .step(rot_step), .clr(base_clr), .base_o(ibase)
    );
    rotrf_base #(.SIZE(PROT), .W(PAW)) u_pbase (
        .clk(clk), .rst_n(rst_n), .step(rot_step), .clr(base_clr), .base_o(pbase)
    );

    assign ilog[0]       = int_ra_idx;
    assign ilog[1]       = int_rb_idx;
    assign ilog[WR_SLOT] = int_wa_idx;
    assign plog[0]       = prd_ra_idx;
    assign plog[1]       = prd_rb_idx;
    assign plog[WR_SLOT] = prd_wa_idx;

    for (genvar k = 0; k < MAP_UNITS; k++) begin : g_map
        rotrf_map #(.ENTRIES(INT_REGS), .FIXED(INT_FIXED), .W(IAW)) u_imap (
            .idx(ilog[k]), .base(ibase), .phys(iphys[k])
        );
        rotrf_map #(.ENTRIES(PRD_REGS), .FIXED(PRD_FIXED), .W(PAW)) u_pmap (
            .idx(plog[k]), .base(pbase), .phys(pphys[k])
        );
    end

    for (genvar r = 0; r < RD_PORTS; r++) begin : g_raddr
        assign iraddr[r] = iphys[r];
        assign praddr[r] = pphys[r];
    end

    rotrf_bank #(
        .ENTRIES(INT_REGS), .WIDTH(IWIDTH), .NREAD(RD_PORTS), .AW(IAW),
        .CONST0('0)
    ) u_ibank (
        .clk(clk), .rst_n(rst_n),
        .we(int_we), .wa(iphys[WR_SLOT]), .wd({int_wa_nat, int_wa_data}),
        .ra(iraddr), .rd(irdata)
    );

    rotrf_bank #(
        .ENTRIES(PRD_REGS), .WIDTH(1), .NREAD(RD_PORTS), .AW(PAW),
        .CONST0(1'b1)
    ) u_pbank (
        .clk(clk), .rst_n(rst_n),
        .we(prd_we), .wa(pphys[WR_SLOT]), .wd(prd_wa_val),
        .ra(praddr), .rd(prdata)
    );

    assign {int_ra_nat, int_ra_data} = irdata[0];
    assign {int_rb_nat, int_rb_data} = irdata[1];
    assign prd_ra_val = prdata[0][0];
    assign prd_rb_val = prdata[1][0];
endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IROT = 96,
    parameter int unsigned PROT = 48,
    parameter int unsigned IAW  = 7,
    parameter int unsigned PAW  = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rot_step,
    input logic            base_clr,
    input logic [IAW-1:0]  int_ra_idx,
    input logic [XLEN-1:0] int_ra_data,
    input logic            int_ra_nat,
    input logic            int_we,
    input logic [IAW-1:0]  int_wa_idx,
    input logic [XLEN-1:0] int_wa_data,
    input logic [PAW-1:0]  prd_ra_idx,
    input logic            prd_ra_val,
    input logic [IAW-1:0]  ibase,
    input logic [PAW-1:0]  pbase
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ra_idx == '0) |-> (int_ra_data == '0 && !int_ra_nat));

    a_r3_pred0_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_ra_idx == '0) |-> prd_ra_val);

    a_r8_same_cycle_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (int_we && int_wa_idx == int_ra_idx && int_wa_idx != '0)
        |-> (int_ra_data == int_wa_data));

    a_r1_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(int_we && int_wa_idx != '0 && !rot_step && !base_clr)
         && int_ra_idx == $past(int_wa_idx)
         && !(int_we && int_wa_idx == int_ra_idx))
        |-> (int_ra_data == $past(int_wa_data)));

    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(base_clr)) |-> (ibase == '0 && pbase == '0));

    a_r6_step_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rot_step && !base_clr))
        |-> (ibase == (($past(ibase) == '0) ? IAW'(IROT - 1) : $past(ibase) - 1'b1)));

    a_r6_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ibase < IAW'(IROT)) && (pbase < PAW'(PROT)));

    a_r5_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!rot_step && !base_clr)) |-> ($stable(ibase) && $stable(pbase)));
endmodule

bind rot_regfile rot_regfile_chk #(
    .XLEN(XLEN), .IROT(INT_REGS - INT_FIXED), .PROT(PRD_REGS - PRD_FIXED),
    .IAW(IAW), .PAW(PAW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rot_step(rot_step), .base_clr(base_clr),
    .int_ra_idx(int_ra_idx), .int_ra_data(int_ra_data), .int_ra_nat(int_ra_nat),
    .int_we(int_we), .int_wa_idx(int_wa_idx), .int_wa_data(int_wa_data),
    .prd_ra_idx(prd_ra_idx), .prd_ra_val(prd_ra_val),
    .ibase(ibase), .pbase(pbase)
);

// File: tb/rot_regfile_tb.sv
module rot_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rot_step = 1'b0, base_clr = 1'b0;
    logic [6:0]  int_ra_idx = '0, int_rb_idx = '0, int_wa_idx = '0;
    logic [63:0] int_ra_data, int_rb_data, int_wa_data = '0;
    logic        int_ra_nat, int_rb_nat, int_we = 1'b0, int_wa_nat = 1'b0;
    logic [5:0]  prd_ra_idx = '0, prd_rb_idx = '0, prd_wa_idx = '0;
    logic        prd_ra_val, prd_rb_val, prd_we = 1'b0, prd_wa_val = 1'b0;

    always #5 clk = ~clk;

    rot_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .rot_step(rot_step), .base_clr(base_clr),
        .int_ra_idx(int_ra_idx), .int_ra_data(int_ra_data), .int_ra_nat(int_ra_nat),
        .int_rb_idx(int_rb_idx), .int_rb_data(int_rb_data), .int_rb_nat(int_rb_nat),
        .int_we(int_we), .int_wa_idx(int_wa_idx), .int_wa_data(int_wa_data),
        .int_wa_nat(int_wa_nat),
        .prd_ra_idx(prd_ra_idx), .prd_ra_val(prd_ra_val),
        .prd_rb_idx(prd_rb_idx), .prd_rb_val(prd_rb_val),
        .prd_we(prd_we), .prd_wa_idx(prd_wa_idx), .prd_wa_val(prd_wa_val)
    );

    typedef struct {
        string       tag;
        logic [64:0] ea, eb;
        logic        pa, pb;
    } item_t;

    item_t q[$];
    int errors = 0, checks = 0;
    bit done = 0;

    // independent reference state
    logic [64:0] imem[128];
    logic        pmem[64];
    int          ib = 0, pb = 0;

    function automatic int imap(int i);
        if (i < 32) return i;
        return ((i - 32 + ib) % 96) + 32;
    endfunction
    function automatic int pmap(int i);
        if (i < 16) return i;
        return ((i - 16 + pb) % 48) + 16;
    endfunction

    function automatic logic [64:0] iexp(int i, bit we, int wa, logic [64:0] w);
        if (i == 0) return '0;
        if (we && wa != 0 && imap(wa) == imap(i)) return w;
        return imem[imap(i)];
    endfunction
    function automatic logic pexp(int i, bit we, int wa, logic w);
        if (i == 0) return 1'b1;
        if (we && wa != 0 && pmap(wa) == pmap(i)) return w;
        return pmem[pmap(i)];
    endfunction

    task automatic drive(string tag, int ia, int ibx, bit we, int wa, logic [63:0] wd,
                         bit wn, int pa, int pbx, bit pwe, int pwa, bit pwv,
                         bit st, bit cl);
        item_t it;
        @(negedge clk); #1;
        int_ra_idx = 7'(ia); int_rb_idx = 7'(ibx);
        int_we = we; int_wa_idx = 7'(wa); int_wa_data = wd; int_wa_nat = wn;
        prd_ra_idx = 6'(pa); prd_rb_idx = 6'(pbx);
        prd_we = pwe; prd_wa_idx = 6'(pwa); prd_wa_val = pwv;
        rot_step = st; base_clr = cl;
        it.tag = tag;
        it.ea = iexp(ia, we, wa, {wn, wd});
        it.eb = iexp(ibx, we, wa, {wn, wd});
        it.pa = pexp(pa, pwe, pwa, pwv);
        it.pb = pexp(pbx, pwe, pwa, pwv);
        q.push_back(it);
        if (we && wa != 0) imem[imap(wa)] = {wn, wd};
        if (pwe && pwa != 0) pmem[pmap(pwa)] = pwv;
        if (cl) begin
            ib = 0; pb = 0;
        end else if (st) begin
            ib = (ib == 0) ? 95 : ib - 1;
            pb = (pb == 0) ? 47 : pb - 1;
        end
    endtask

    task automatic rd(string tag, int ia, int ibx, int pa, int pbx);
        drive(tag, ia, ibx, 0, 0, '0, 0, pa, pbx, 0, 0, 0, 0, 0);
    endtask
    task automatic wi(string tag, int wa, logic [63:0] wd, bit wn);
        drive(tag, wa, 0, 1, wa, wd, wn, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wp(string tag, int wa, bit v);
        drive(tag, 0, 0, 0, 0, '0, 0, wa, 0, 1, wa, v, 0, 0);
    endtask
    task automatic stepc(string tag, bit cl);
        drive(tag, 7, 0, 0, 0, '0, 0, 5, 0, 0, 0, 0, 1, cl);
    endtask

    task automatic cmp1(string tag, string what, logic [64:0] got, logic [64:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // monitor: sample mid-cycle, before the next rising edge
    initial begin
        forever begin
            @(negedge clk); #3;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                cmp1(it.tag, "int A", {int_ra_nat, int_ra_data}, it.ea);
                cmp1(it.tag, "int B", {int_rb_nat, int_rb_data}, it.eb);
                cmp1(it.tag, "prd A", 65'(prd_ra_val), 65'(it.pa));
                cmp1(it.tag, "prd B", 65'(prd_rb_val), 65'(it.pb));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) imem[i] = '0;
        for (int i = 0; i < 64; i++) pmem[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd("R9 reset clear", 5, 100, 3, 40);
        rd("R9 reset clear top, R3 pred0", 127, 31, 0, 63);

        drive("R2 write r0 same cycle", 0, 0, 1, 0, 64'hDEAD_BEEF_0000_0001, 1,
              0, 0, 1, 0, 0, 0, 0);
        rd("R2 R3 index 0 after write", 0, 0, 0, 0);

        wi("R1 write", 7, 64'h0123_4567_89AB_CDEF, 0);
        wi("R1 write", 40, 64'hB0B0_B0B0_0000_0040, 1);
        wi("R1 write", 32, 64'hC0C0_0000_0000_0032, 0);
        wi("R1 write", 127, 64'hD0D0_0000_0000_007F, 1);
        wi("R1 write", 31, 64'hE0E0_0000_0000_001F, 0);
        wp("R1 write pred", 5, 1);
        wp("R1 write pred", 16, 1);
        wp("R1 write pred", 63, 1);
        wp("R1 write pred", 15, 1);
        rd("R1 readback", 7, 40, 5, 16);
        rd("R1 readback", 32, 127, 63, 15);

        drive("R8 forward", 50, 50, 1, 50, 64'h5050_5050_5050_5050, 1,
              20, 20, 1, 20, 1, 0, 0);

        stepc("R6 step", 0);
        rd("R6 shifted names", 33, 32, 17, 16);
        rd("R4 fixed after step", 7, 31, 5, 15);

        for (int k = 0; k < 95; k++) stepc("R6 lap", 0);
        rd("R6 full lap", 40, 127, 16, 63);

        stepc("R8 step", 0);
        drive("R8 forward renamed", 60, 60, 1, 60, 64'h6060_0000_0000_0060, 0,
              30, 30, 1, 30, 1, 0, 0);
        rd("R5 renamed store", 60, 61, 30, 31);

        stepc("R7 step", 0);
        stepc("R7 step", 0);
        stepc("R7 step and clear", 1);
        rd("R7 offsets zero", 32, 127, 16, 63);
        rd("R4 fixed after clear", 7, 31, 5, 15);

        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom % 32;
            drive("R5 random", $urandom % 128, $urandom % 128, ($urandom % 2) == 1,
                  $urandom % 128, {$urandom, $urandom}, ($urandom % 2) == 1,
                  $urandom % 64, $urandom % 64, ($urandom % 2) == 1,
                  $urandom % 64, ($urandom % 2) == 1, r < 6, r == 31);
        end
        rd("R4 fixed after random", 7, 31, 5, 15);

        rd("idle", 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule